// File: doc/BRIEF.md
# CRC-Checked Serial Configuration Register Port

This block is the serial slave side of a small configuration register bank. The host talks to it in SPI mode 0. The host pulls chip select low, sends bits most significant first on MOSI, and raises chip select to close the frame. Every frame carries an 8-bit CRC.

On a write, the host follows the command byte with the data bytes and then a CRC byte. The block recomputes the CRC from what it received. It commits the data only when the two CRCs match and the frame carried exactly the expected number of clock pulses. On a read, the block returns the register value and then a CRC over the command and data, so the host can check the reply.

Errors are not silent. A CRC mismatch raises a sticky CRC error flag. A wrong clock count raises a sticky clock error flag. Both flags stay set until the host clears them through a status register. All serial inputs are synchronised into the system clock domain and sampled there. The register contents leave the block on one flat configuration bus, which feeds the analog blocks.

Top module: `crc_spi_regs`

## Requirements
- R1: After reset, every configuration bit is 0, both error flags are 0, and `miso_o` is 0.
- R2: Command byte layout: bit 7 is 1 for a read and 0 for a write. Bits 2:0 hold the address, and bits 6:3 are ignored. The data widths by address are: addresses 0 and 1 are 8 bits, addresses 2 and 3 are 16 bits, and addresses 4 to 6 are 24 bits. Address 7 is the 8-bit status register. In it, bit 0 is the CRC error flag and bit 1 is the clock error flag.
- R3: A write frame is the command byte, then the data bytes (most significant first), then a CRC byte. The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It is computed MSB first over the command byte and the data bytes, with no reflection and no final XOR. When chip select rises and the received CRC matches the computed one, the data is written to the addressed register.
- R4: When the received CRC does not match on a write, the CRC error flag is set and no configuration bit changes.
- R5: A frame must carry exactly 8 × (data bytes + 2) rising clock edges. This includes frames shorter than one byte. Any other count sets the clock error flag and suppresses the write, even if the CRC matches.
- R6: On a read, `miso_o` presents the register value MSB first for the host to sample on rising edges 9 onward. The CRC byte over the command and data follows it. A read never changes any configuration bit.
- R7: The error flags are sticky. A valid write to address 7 clears each flag whose data bit is 1 and leaves a flag alone when its bit is 0.
- R8: A read frame with the wrong clock count sets the clock error flag.
- R9: `cfg_o` packs the registers from address 0 upward, starting at bit 0, each at its own width: bit offsets 0, 8, 16, 32, 48, 72 and 96.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| cfg_o | output | 120 | Packed configuration register contents |
| crc_err_o | output | 1 | Sticky CRC error flag |
| clk_err_o | output | 1 | Sticky clock count error flag |

## Verification
The bench targets four failure classes:

- **Boundary clock counts.** It sends frames one bit short, one bit long and only a few bits long, each with an otherwise correct CRC. A design that checks only the CRC, or only a minimum length, would commit the data.
- **Corrupted CRC bytes.** These catch a design that writes before it compares, and they must leave the registers untouched.
- **Read replies.** The bench checks the CRC on every read reply. A reply whose CRC skips the command byte, or starts one bit off, shows up at once.
- **Status clears.** The bench writes 1 and 0 patterns to the status register. A design that clears both flags together, or treats the flags as level signals, would clear a flag that should stay set.

Random frames with arbitrary ignored command bits are mixed in to catch address decoding that looks at the wrong bits.

// File: rtl/crc_spi_regs_pkg.sv
package crc_spi_regs_pkg;

    localparam int ADDR_W      = 3;
    localparam int NUM_ADDR    = 1 << ADDR_W;
    localparam int STATUS_ADDR = NUM_ADDR - 1;
    localparam int MAX_BYTES   = 3;
    localparam int DATA_W      = 8 * MAX_BYTES;
    localparam int SHIFT_W     = DATA_W + 8;
    localparam int CNT_W       = 6;
    localparam logic [7:0] CRC_POLY = 8'h07;

    // Bytes held by each address; the status register is one byte.
    function automatic int reg_bytes(input logic [ADDR_W-1:0] a);
        if (int'(a) < 2)      return 1;
        else if (int'(a) < 4) return 2;
        else if (int'(a) < 7) return 3;
        else                  return 1;
    endfunction

    // Bit offset of an address inside the packed configuration bus.
    function automatic int reg_offset(input logic [ADDR_W-1:0] a);
        int off;
        off = 0;
        for (int i = 0; i < NUM_ADDR; i++)
            if (i < int'(a)) off += 8 * reg_bytes(ADDR_W'(i));
        return off;
    endfunction

    localparam int CFG_W = reg_offset(ADDR_W'(STATUS_ADDR));

    function automatic logic [7:0] crc8_bit(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

    // Continue a CRC over the low nb bytes of d, most significant bit first.
    function automatic logic [7:0] crc8_data(input logic [7:0] c, input logic [DATA_W-1:0] d,
                                             input int nb);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < DATA_W; i++)
            if (i < 8 * nb) r = crc8_bit(r, d[8 * nb - 1 - i]);
        return r;
    endfunction

    typedef struct packed {
        logic [7:0]        cmd;
        logic [CNT_W-1:0]  bits;
        logic [DATA_W-1:0] data;
        logic [7:0]        rx_crc;
        logic [7:0]        calc_crc;
    } frame_t;

endpackage

// File: rtl/crc_spi_sync.sv
module crc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_start_o,
    output logic cs_end_o,
    output logic cs_active_o,
    output logic mosi_o
);

    typedef struct packed {
        logic [STAGES:0]   sclk;
        logic [STAGES:0]   csn;
        logic [STAGES-1:0] mosi;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sclk = {q.sclk[STAGES-1:0], sclk_i};
        d.csn  = {q.csn[STAGES-1:0], cs_n_i};
        d.mosi = {q.mosi[STAGES-2:0], mosi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sclk <= '0;
            q.csn  <= '1;
            q.mosi <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_rise_o = q.sclk[STAGES-1] & ~q.sclk[STAGES];
    assign sclk_fall_o = ~q.sclk[STAGES-1] & q.sclk[STAGES];
    assign cs_start_o  = ~q.csn[STAGES-1] & q.csn[STAGES];
    assign cs_end_o    = q.csn[STAGES-1] & ~q.csn[STAGES];
    assign cs_active_o = ~q.csn[STAGES-1];
    assign mosi_o      = q.mosi[STAGES-1];

endmodule

// File: rtl/crc_spi_frame.sv
module crc_spi_frame
    import crc_spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    input  logic              cs_start_i,
    input  logic              cs_end_i,
    input  logic              cs_active_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              miso_o,
    output logic              done_o,
    output frame_t            res_o
);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [7:0]         cmd;
        logic [SHIFT_W-1:0] rx;
        logic [7:0]         crc;
        logic [SHIFT_W-1:0] tx;
        logic               load;
        logic               done;
        frame_t             res;
    } frame_st_t;

    frame_st_t q, d;
    int         nb_d;
    logic [7:0] tx_crc_d;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.load   = 1'b0;
        nb_d     = reg_bytes(q.cmd[ADDR_W-1:0]);
        tx_crc_d = crc8_data(q.crc, rd_data_i, nb_d);
        if (cs_start_i) begin
            d.cnt = '0;
            d.cmd = '0;
            d.rx  = '0;
            d.crc = '0;
            d.tx  = '0;
        end else if (cs_end_i) begin
            d.done         = 1'b1;
            d.res.cmd      = q.cmd;
            d.res.bits     = q.cnt;
            d.res.data     = q.rx[SHIFT_W-1:8];
            d.res.rx_crc   = q.rx[7:0];
            d.res.calc_crc = q.crc;
            d.tx           = '0;
        end else if (cs_active_i) begin
            // Reply for a read: data then CRC, left aligned at the shift MSB.
            if (q.load && q.cmd[7])
                d.tx = {rd_data_i, tx_crc_d} << (8 * (MAX_BYTES - nb_d));
            if (sclk_rise_i) begin
                d.rx = {q.rx[SHIFT_W-2:0], mosi_i};
                if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
                if (int'(q.cnt) < 8 || int'(q.cnt) < 8 * (1 + nb_d))
                    d.crc = crc8_bit(q.crc, mosi_i);
                if (int'(q.cnt) == 7) begin
                    d.cmd  = {q.rx[6:0], mosi_i};
                    d.load = 1'b1;
                end
            end
            if (sclk_fall_i && int'(q.cnt) >= 9)
                d.tx = {q.tx[SHIFT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr_o = q.cmd[ADDR_W-1:0];
    assign miso_o    = q.tx[SHIFT_W-1];
    assign done_o    = q.done;
    assign res_o     = q.res;

endmodule

// File: rtl/crc_spi_regbank.sv
module crc_spi_regbank
    import crc_spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  frame_t            res_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CFG_W-1:0]  cfg_o,
    output logic              crc_err_o,
    output logic              clk_err_o
);

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             crc_err;
        logic             clk_err;
    } bank_t;

    bank_t             q, d;
    logic [ADDR_W-1:0] wa_d;
    int                wnb_d;
    logic              cnt_ok_d;

    always_comb begin
        d        = q;
        wa_d     = res_i.cmd[ADDR_W-1:0];
        wnb_d    = reg_bytes(wa_d);
        cnt_ok_d = (int'(res_i.bits) == 8 * (wnb_d + 2));
        if (done_i) begin
            if (!cnt_ok_d) begin
                d.clk_err = 1'b1;
            end else if (!res_i.cmd[7]) begin
                if (res_i.rx_crc != res_i.calc_crc) begin
                    d.crc_err = 1'b1;
                end else if (int'(wa_d) == STATUS_ADDR) begin
                    if (res_i.data[0]) d.crc_err = 1'b0;
                    if (res_i.data[1]) d.clk_err = 1'b0;
                end else begin
                    for (int a = 0; a < STATUS_ADDR; a++)
                        for (int b = 0; b < DATA_W; b++)
                            if (int'(wa_d) == a && b < 8 * reg_bytes(ADDR_W'(a)))
                                d.cfg[reg_offset(ADDR_W'(a)) + b] = res_i.data[b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        if (int'(rd_addr_i) == STATUS_ADDR) begin
            rd_data_o[1:0] = {q.clk_err, q.crc_err};
        end else begin
            for (int a = 0; a < STATUS_ADDR; a++)
                for (int b = 0; b < DATA_W; b++)
                    if (int'(rd_addr_i) == a && b < 8 * reg_bytes(ADDR_W'(a)))
                        rd_data_o[b] = q.cfg[reg_offset(ADDR_W'(a)) + b];
        end
    end

    assign cfg_o     = q.cfg;
    assign crc_err_o = q.crc_err;
    assign clk_err_o = q.clk_err;

endmodule

// File: rtl/crc_spi_regs.sv
module crc_spi_regs
    import crc_spi_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             cs_n_i,
    input  logic             mosi_i,
    output logic             miso_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             crc_err_o,
    output logic             clk_err_o
);

    logic              sclk_rise, sclk_fall, cs_start, cs_end, cs_active, mosi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              frame_done;
    frame_t            frame_res;

    crc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .cs_n_i      (cs_n_i),
        .mosi_i      (mosi_i),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .cs_start_o  (cs_start),
        .cs_end_o    (cs_end),
        .cs_active_o (cs_active),
        .mosi_o      (mosi_s)
    );

    crc_spi_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .cs_start_i  (cs_start),
        .cs_end_i    (cs_end),
        .cs_active_i (cs_active),
        .mosi_i      (mosi_s),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .miso_o      (miso_o),
        .done_o      (frame_done),
        .res_o       (frame_res)
    );

    crc_spi_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (frame_done),
        .res_i     (frame_res),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .cfg_o     (cfg_o),
        .crc_err_o (crc_err_o),
        .clk_err_o (clk_err_o)
    );

endmodule

// File: rtl/crc_spi_regs_chk.sv
module crc_spi_regs_chk
    import crc_spi_regs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_o,
    input logic             crc_err_o,
    input logic             clk_err_o,
    input logic             miso_o,
    input logic             frame_done
);

    // R3: configuration bits change only in the cycle after a frame closes
    p_cfg_only_after_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> $past(frame_done));

    // R4: raising the CRC flag never coincides with a register update
    p_crc_err_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err_o) |-> $stable(cfg_o));

    // R5: raising the clock flag never coincides with a register update
    p_clk_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_err_o) |-> $stable(cfg_o));

    // R7: flags drop only as the result of a closed frame
    p_crc_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_err_o) |-> $past(frame_done));

    p_clk_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_err_o) |-> $past(frame_done));

    // R6: the reply line is quiet once the frame has closed
    p_miso_quiet_after_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !miso_o);

endmodule

bind crc_spi_regs crc_spi_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_o      (cfg_o),
    .crc_err_o  (crc_err_o),
    .clk_err_o  (clk_err_o),
    .miso_o     (miso_o),
    .frame_done (frame_done)
);

// File: tb/crc_spi_regs_test.sv
`timescale 1ns/1ps
module crc_spi_regs_test;

    localparam int HALF = 8;
    localparam int CW   = 120;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic          cs_n = 1'b1;
    logic          mosi = 1'b0;
    logic          miso;
    logic [CW-1:0] cfg;
    logic          crc_err, clk_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [23:0] mreg [7];
    logic        m_crc, m_clk;

    always #10 clk = ~clk;

    crc_spi_regs uut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .mosi_i(mosi),
        .miso_o(miso), .cfg_o(cfg), .crc_err_o(crc_err), .clk_err_o(clk_err)
    );

    function automatic int nbytes(input int a);
        if (a < 2) return 1;
        if (a < 4) return 2;
        if (a < 7) return 3;
        return 1;
    endfunction

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ b[i]) r = {r[6:0], 1'b0} ^ 8'h07;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] frame_crc(input logic [7:0] cmd, input logic [23:0] data, input int nb);
        logic [7:0] r;
        r = crc_byte(8'h00, cmd);
        for (int j = 0; j < nb; j++) r = crc_byte(r, data[8 * (nb - 1 - j) +: 8]);
        return r;
    endfunction

    function automatic logic [CW-1:0] model_cfg();
        logic [CW-1:0] v;
        int off;
        v = '0;
        off = 0;
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 8 * nbytes(a); b++) v[off + b] = mreg[a][b];
            off += 8 * nbytes(a);
        end
        return v;
    endfunction

    function automatic logic [23:0] mask(input int nb);
        return 24'hFFFFFF >> (8 * (3 - nb));
    endfunction

    task automatic chk(input string req, input string what, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] cmd, input logic [23:0] data, input int nb,
                             input logic [7:0] crc, input int total, output logic [47:0] rb);
        logic [47:0] s;
        s = '0;
        rb = '0;
        s[47:40] = cmd;
        for (int j = 0; j < nb; j++) s[39 - 8 * j -: 8] = data[8 * (nb - 1 - j) +: 8];
        s[39 - 8 * nb -: 8] = crc;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < total; i++) begin
            mosi = (i < 48) ? s[47 - i] : 1'b0;
            wait_clk(HALF);
            if (i < 48) rb[47 - i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(2 * HALF);
    endtask

    task automatic check_state(input string req);
        chk(req, "cfg", cfg, model_cfg());
        chk(req, "flags", {118'b0, clk_err, crc_err}, {118'b0, m_clk, m_crc});
        chk(req, "miso idle", {119'b0, miso}, '0);
    endtask

    // delta: extra (+) or missing (-) clock pulses; bad: corrupt the CRC byte
    task automatic do_write(input string req, input int addr, input logic [23:0] data,
                            input logic [3:0] upper, input bit bad, input int delta);
        logic [7:0]  cmd, c, rc;
        logic [47:0] rb;
        int nb, total;
        nb    = nbytes(addr);
        cmd   = {1'b0, upper, 3'(addr)};
        data  = data & mask(nb);
        c     = frame_crc(cmd, data, nb);
        rc    = bad ? (c ^ 8'h5A) : c;
        total = 8 * (nb + 2) + delta;
        if (total < 0) total = 0;
        run_frame(cmd, data, nb, rc, total, rb);
        if (total != 8 * (nb + 2))  m_clk = 1'b1;
        else if (rc != c)           m_crc = 1'b1;
        else if (addr == 7) begin
            if (data[0]) m_crc = 1'b0;
            if (data[1]) m_clk = 1'b0;
        end else mreg[addr] = data;
        check_state(req);
    endtask

    task automatic do_read(input string req, input int addr, input logic [3:0] upper, input int delta);
        logic [7:0]  cmd, c;
        logic [23:0] ev, got;
        logic [47:0] rb;
        int nb, total;
        nb    = nbytes(addr);
        cmd   = {1'b1, upper, 3'(addr)};
        ev    = (addr == 7) ? {22'b0, m_clk, m_crc} : mreg[addr];
        c     = frame_crc(cmd, ev, nb);
        total = 8 * (nb + 2) + delta;
        run_frame(cmd, 24'h0, nb, 8'h00, total, rb);
        if (delta >= 0) begin
            got = rb[39 -: 24] >> (8 * (3 - nb));
            chk(req, "read data", {96'b0, got}, {96'b0, ev});
            chk(req, "read crc", {112'b0, rb[39 - 8 * nb -: 8]}, {112'b0, c});
        end
        if (delta != 0) m_clk = 1'b1;
        check_state(req);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int a = 0; a < 7; a++) mreg[a] = '0;
        m_crc = 1'b0;
        m_clk = 1'b0;
        wait_clk(5);
        check_state("R1");
        rst_n = 1'b1;
        wait_clk(5);
        check_state("R1");

        // R3 / R9: valid writes to every data register
        for (int a = 0; a < 7; a++)
            do_write("R3", a, 24'hA5C3E1 ^ (24'h111111 * a), 4'h0, 0, 0);
        chk("R9", "offset 48", {96'b0, cfg[48 +: 24]}, {96'b0, mreg[4]});
        chk("R9", "offset 16", {104'b0, cfg[16 +: 16]}, {104'b0, mreg[2][15:0]});

        // R6: read back each register, with its reply CRC
        for (int a = 0; a < 8; a++) do_read("R6", a, 4'h0, 0);

        // R2: ignored command bits do not change the address decode
        do_write("R2", 3, 24'h00BEEF, 4'hF, 0, 0);
        do_read("R2", 3, 4'h9, 0);

        // R4: corrupted CRC sets the flag and leaves the register alone
        do_write("R4", 5, 24'h123456, 4'h0, 1, 0);
        do_read("R4", 7, 4'h0, 0);

        // R7: writing 0 leaves the flag, writing 1 clears it
        do_write("R7", 7, 24'h000000, 4'h0, 0, 0);
        do_write("R7", 7, 24'h000001, 4'h0, 0, 0);

        // R5: off-by-one and short frames with good CRC are rejected
        do_write("R5", 1, 24'h00005A, 4'h0, 0, -1);
        do_write("R5", 4, 24'h0F0F0F, 4'h0, 0, 1);
        do_write("R7", 7, 24'h000001, 4'h0, 0, 0);
        do_write("R5", 2, 24'h00FFFF, 4'h0, 0, -28);
        do_write("R5", 6, 24'h777777, 4'h0, 1, 2);
        do_read("R5", 7, 4'h0, 0);
        do_write("R7", 7, 24'h000002, 4'h0, 0, 0);

        // R8: read frames with a wrong count flag a clock error
        do_read("R8", 4, 4'h0, 3);
        do_write("R7", 7, 24'h000003, 4'h0, 0, 0);
        do_read("R8", 2, 4'h0, -5);
        do_write("R7", 7, 24'h000003, 4'h0, 0, 0);

        // random mix
        for (int n = 0; n < 50; n++) begin
            int op, a, dl;
            op = $urandom % 5;
            a  = $urandom % 8;
            if (op < 2)       do_write("R3", a, 24'($urandom), 4'($urandom), 0, 0);
            else if (op == 2) do_read("R6", a, 4'($urandom), 0);
            else if (op == 3) do_write("R4", a, 24'($urandom), 4'($urandom), 1, 0);
            else begin
                dl = int'($urandom % 5) - 2;
                if (dl == 0) dl = 1;
                do_write("R5", a, 24'($urandom), 4'($urandom), $urandom % 2, dl);
            end
        end
        do_read("R7", 7, 4'h0, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule